// File: doc/BRIEF.md
# Reference Selection Mode Controller

This block is the control state machine of a network clock synchronizer. It chooses which of three timing references (primary, secondary, tertiary) feeds the phase-locked loop. It also moves the loop through four states: Freerun, Normal, Holdover and a one-cycle phase-offset correction state. It does not contain the loop or the phase storage. It tells them which reference is active, when the loop is coasting, and when to capture the current phase offset.

The two mode-select bits choose between manual and automatic operation. In manual operation the reference-select pins name the active reference. In automatic operation the block picks between the primary and secondary references itself and reports its choice. Per-reference fail flags come from an upstream monitor that has already qualified them. A hitless-recovery input decides whether leaving Holdover keeps the phase offset (through the correction state) or realigns the output to the input (directly to Normal).

Top module: `refsel_mode_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, the active reference is the primary (index 0), the holdover output is 1 and the correction strobe is 0.
- R2: After reset the block stays in Freerun (holdover output 1) until the reference wanted by the current mode is valid. It then goes straight to Normal without a correction strobe.
- R3: With mode-select other than binary 11 (manual), the active reference follows the select pins: 00 selects primary (index 0), 01 selects secondary (index 1), 10 and 11 select tertiary (index 2). In manual mode the reported-select output echoes the select pins. In automatic mode it gives the active index.
- R4: In Normal, a manual change of the select pins to a valid reference gives exactly one cycle with the correction strobe high on the new index, and then Normal.
- R5: When the active reference fails and the current mode offers no valid alternative, the block enters Holdover the next cycle and stays there while the condition holds.
- R6: In automatic mode after reset, with both primary and secondary valid, the primary is chosen.
- R7: In automatic mode the choice is non-revertive. Once on the secondary, a recovered primary does not cause a switch back.
- R8: On entering automatic mode while the tertiary is active, the primary is preferred over the secondary.
- R9: In automatic mode, with both primary and secondary failed, the block enters Holdover and keeps its active index. It never moves to the tertiary.
- R10: Leaving Holdover with the recovery input low goes straight to Normal. With it high, the block first spends one cycle in the correction state with the strobe high.
- R11: The holdover output is 1 exactly in Freerun and Holdover. The correction strobe never coincides with it and never lasts two cycles in a row.
- R12: In automatic mode in Normal, a failure of the active primary or secondary, with the other one valid, gives a one-cycle correction strobe on the other index and then Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel_i | input | 2 | 11 = automatic selection, other values = manual |
| ref_sel_i | input | 2 | Manual reference select (00 primary, 01 secondary, 1x tertiary) |
| ref_fail_i | input | 3 | Per-reference fail flags, bit n for reference n, 1 = failed |
| hitless_i | input | 1 | Holdover recovery path: 1 keeps phase offset, 0 realigns |
| active_ref_o | output | 2 | Index of the active reference |
| holdover_o | output | 1 | High in Freerun or Holdover |
| ref_rpt_o | output | 2 | Reported select value (active index in automatic mode) |
| tie_strobe_o | output | 1 | One-cycle pulse in the phase-offset correction state |

## Verification
The properties assume that every input is synchronous to the clock and stable around its rising edge. They also assume the fail flags are already filtered, so a flag may change on any cycle without glitching inside one. No relation between the flags, the mode bits or the select pins is assumed, so each may change on any cycle, even during the correction cycle. The stimulus changes all inputs only on the falling edge. Fail flags toggle independently with a small probability each cycle, and mode and select changes are rarer, so the block visits every state and transition, including changes that land in the correction cycle.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the reference selection mode controller.
// Assumes a two-bit mode field in which one code means automatic selection.
package refsel_pkg;

    // Loop control states; encoding is internal only.
    typedef enum logic [1:0] {
        ST_FREERUN  = 2'd0,
        ST_NORMAL   = 2'd1,
        ST_HOLDOVER = 2'd2,
        ST_TIECORR  = 2'd3
    } loop_state_t;

    // Mode-select code that enables automatic reference choice.
    localparam logic [1:0] MODE_AUTO = 2'b11;

endpackage

// File: rtl/refsel_manual_pick.sv
`timescale 1ns/1ps
// Module: refsel_manual_pick
// Maps the manual select pins to a reference index and reports whether
// that reference is currently valid. Codes at or above the last index
// all map to the last (tertiary) reference.
// Assumes NUM_REFS >= 2 and that fail flags are already qualified.
module refsel_manual_pick #(
    parameter int NUM_REFS = 3,
    parameter int SEL_W    = 2,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [NUM_REFS-1:0] fail_i,
    output logic [IDX_W-1:0]    want_o,
    output logic                ok_o
);
    localparam int LAST = NUM_REFS - 1;

    // Clamp the select code to the highest reference and look up its flag.
    always_comb begin
        if (int'(sel_i) >= LAST) begin
            want_o = IDX_W'(LAST);
        end else begin
            want_o = IDX_W'(sel_i);
        end
        ok_o = !fail_i[want_o];
    end

endmodule

// File: rtl/refsel_auto_pick.sv
`timescale 1ns/1ps
// Module: refsel_auto_pick
// Automatic choice between the primary (index 0) and secondary (index 1)
// references. It keeps the current one while valid (non-revertive). From
// the tertiary it prefers the primary. When nothing is valid it reports
// the current index with ok_o low, so the caller keeps its index.
// Assumes NUM_REFS >= 3; the tertiary is the last index and never chosen.
module refsel_auto_pick #(
    parameter int NUM_REFS = 3,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input  logic [IDX_W-1:0]    cur_i,
    input  logic [NUM_REFS-1:0] fail_i,
    output logic [IDX_W-1:0]    want_o,
    output logic                ok_o
);
    localparam int PRI = 0;
    localparam int SEC = 1;
    localparam int TER = NUM_REFS - 1;

    logic [IDX_W-1:0] other_idx;

    // The alternative between primary and secondary.
    always_comb begin
        other_idx = (cur_i == IDX_W'(PRI)) ? IDX_W'(SEC) : IDX_W'(PRI);
    end

    // Priority / non-revertive decision.
    always_comb begin
        want_o = cur_i;
        ok_o   = 1'b0;
        if (cur_i == IDX_W'(TER)) begin
            if (!fail_i[PRI]) begin
                want_o = IDX_W'(PRI);
                ok_o   = 1'b1;
            end else if (!fail_i[SEC]) begin
                want_o = IDX_W'(SEC);
                ok_o   = 1'b1;
            end
        end else if (!fail_i[cur_i]) begin
            ok_o = 1'b1;
        end else if (!fail_i[other_idx]) begin
            want_o = other_idx;
            ok_o   = 1'b1;
        end
    end

endmodule

// File: rtl/refsel_fsm.sv
`timescale 1ns/1ps
// Module: refsel_fsm
// Loop control state machine. It takes a wanted reference and its
// validity from the pick logic and holds the active index and the state.
// Assumes want_i/want_ok_i are stable around the clock edge.
module refsel_fsm #(
    parameter int NUM_REFS = 3,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] want_i,
    input  logic             want_ok_i,
    input  logic             hitless_i,
    output logic [IDX_W-1:0] active_o,
    output logic             holdover_o,
    output logic             tie_strobe_o
);
    import refsel_pkg::*;

    loop_state_t      st_q, st_d;
    logic [IDX_W-1:0] act_q, act_d;

    // State and active-index registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_FREERUN;
            act_q <= '0;
        end else begin
            st_q  <= st_d;
            act_q <= act_d;
        end
    end

    // Next-state and next-index decision.
    always_comb begin
        st_d  = st_q;
        act_d = act_q;
        case (st_q)
            ST_FREERUN: begin
                act_d = want_i;
                if (want_ok_i) st_d = ST_NORMAL;
            end
            ST_NORMAL: begin
                if (!(want_ok_i && want_i == act_q)) begin
                    act_d = want_i;
                    st_d  = want_ok_i ? ST_TIECORR : ST_HOLDOVER;
                end
            end
            ST_HOLDOVER: begin
                act_d = want_i;
                if (want_ok_i) st_d = hitless_i ? ST_TIECORR : ST_NORMAL;
            end
            default: begin
                st_d = ST_NORMAL;
            end
        endcase
    end

    // Outputs decoded from registered state.
    always_comb begin
        active_o     = act_q;
        holdover_o   = (st_q == ST_FREERUN) || (st_q == ST_HOLDOVER);
        tie_strobe_o = (st_q == ST_TIECORR);
    end

endmodule

// File: rtl/refsel_mode_ctrl.sv
`timescale 1ns/1ps
// Module: refsel_mode_ctrl (top)
// Reference selection mode controller. It routes either the manual or the
// automatic pick into the loop state machine and reports the selection.
// Assumes all inputs are synchronous to clk and the fail flags are
// already qualified by an upstream monitor.
module refsel_mode_ctrl #(
    parameter int NUM_REFS = 3,
    parameter int SEL_W    = 2,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_sel_i,
    input  logic [SEL_W-1:0]    ref_sel_i,
    input  logic [NUM_REFS-1:0] ref_fail_i,
    input  logic                hitless_i,
    output logic [IDX_W-1:0]    active_ref_o,
    output logic                holdover_o,
    output logic [SEL_W-1:0]    ref_rpt_o,
    output logic                tie_strobe_o
);
    import refsel_pkg::*;

    logic             auto_mode;
    logic [IDX_W-1:0] man_want, auto_want, want;
    logic             man_ok, auto_ok, want_ok;
    logic [IDX_W-1:0] active;

    refsel_manual_pick #(.NUM_REFS(NUM_REFS), .SEL_W(SEL_W)) man_i (
        .sel_i  (ref_sel_i),
        .fail_i (ref_fail_i),
        .want_o (man_want),
        .ok_o   (man_ok)
    );

    refsel_auto_pick #(.NUM_REFS(NUM_REFS)) auto_i (
        .cur_i  (active),
        .fail_i (ref_fail_i),
        .want_o (auto_want),
        .ok_o   (auto_ok)
    );

    // Choose the pick source from the mode field.
    always_comb begin
        auto_mode = (mode_sel_i == MODE_AUTO);
        want      = auto_mode ? auto_want : man_want;
        want_ok   = auto_mode ? auto_ok   : man_ok;
    end

    refsel_fsm #(.NUM_REFS(NUM_REFS)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .want_i       (want),
        .want_ok_i    (want_ok),
        .hitless_i    (hitless_i),
        .active_o     (active),
        .holdover_o   (holdover_o),
        .tie_strobe_o (tie_strobe_o)
    );

    // Report the active index in automatic mode, echo the pins otherwise.
    always_comb begin
        active_ref_o = active;
        ref_rpt_o    = auto_mode ? SEL_W'(active) : ref_sel_i;
    end

endmodule

// File: rtl/refsel_mode_ctrl_checker.sv
`timescale 1ns/1ps
// Module: refsel_mode_ctrl_checker
// Port-level properties of the mode controller, attached with bind.
module refsel_mode_ctrl_checker #(
    parameter int NUM_REFS = 3,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode_sel_i,
    input logic [NUM_REFS-1:0] ref_fail_i,
    input logic [IDX_W-1:0]    active_ref_o,
    input logic                holdover_o,
    input logic                tie_strobe_o
);
    localparam logic [IDX_W-1:0] TER_IDX = IDX_W'(NUM_REFS - 1);

    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tie_strobe_o |=> !tie_strobe_o);

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(tie_strobe_o && holdover_o));

    assert_strobe_then_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tie_strobe_o |=> (!holdover_o && $stable(active_ref_o)));

    assert_fail_leaves_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!holdover_o && !tie_strobe_o && ref_fail_i[active_ref_o])
            |=> (holdover_o || tie_strobe_o));

    assert_auto_no_tertiary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_sel_i) == 2'b11 && active_ref_o != $past(active_ref_o))
            |-> active_ref_o != TER_IDX);

endmodule

bind refsel_mode_ctrl refsel_mode_ctrl_checker #(.NUM_REFS(NUM_REFS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel_i   (mode_sel_i),
    .ref_fail_i   (ref_fail_i),
    .active_ref_o (active_ref_o),
    .holdover_o   (holdover_o),
    .tie_strobe_o (tie_strobe_o)
);

// File: tb/refsel_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module refsel_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic [1:0] ref_sel;
    logic [2:0] ref_fail;
    logic       hitless;
    logic [1:0] active_ref;
    logic       holdover;
    logic [1:0] ref_rpt;
    logic       tie_strobe;

    int n_chk = 0;
    int n_bad = 0;
    int m_st  = 0;   // 0 freerun, 1 normal, 2 holdover, 3 correction
    int m_act = 0;

    always #2.5 clk = ~clk;

    refsel_mode_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel_i   (mode_sel),
        .ref_sel_i    (ref_sel),
        .ref_fail_i   (ref_fail),
        .hitless_i    (hitless),
        .active_ref_o (active_ref),
        .holdover_o   (holdover),
        .ref_rpt_o    (ref_rpt),
        .tie_strobe_o (tie_strobe)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected next state from the requirements, applied to the inputs now driven.
    task automatic model_step();
        int  w;
        bit  ok;
        if (!rst_n) begin
            m_st  = 0;
            m_act = 0;
            return;
        end
        if (mode_sel == 2'b11) begin
            w  = m_act;
            ok = 0;
            if (m_act == 2) begin
                if (!ref_fail[0])      begin w = 0; ok = 1; end
                else if (!ref_fail[1]) begin w = 1; ok = 1; end
            end else if (!ref_fail[m_act]) begin
                ok = 1;
            end else if (!ref_fail[1 - m_act]) begin
                w = 1 - m_act; ok = 1;
            end
        end else begin
            w  = (ref_sel == 2'd0) ? 0 : (ref_sel == 2'd1) ? 1 : 2;
            ok = !ref_fail[w];
        end
        case (m_st)
            0: begin m_act = w; if (ok) m_st = 1; end
            1: begin
                if (!(ok && w == m_act)) begin
                    m_act = w;
                    m_st  = ok ? 3 : 2;
                end
            end
            2: begin m_act = w; if (ok) m_st = hitless ? 3 : 1; end
            default: m_st = 1;
        endcase
    endtask

    task automatic check_all(string tag);
        int exp_rpt;
        exp_rpt = (mode_sel == 2'b11) ? m_act : int'(ref_sel);
        check({tag, " active"},   int'(active_ref), m_act);
        check({tag, " holdover"}, int'(holdover),   (m_st == 0 || m_st == 2) ? 1 : 0);
        check({tag, " strobe"},   int'(tie_strobe), (m_st == 3) ? 1 : 0);
        check({tag, " report"},   int'(ref_rpt),    exp_rpt);
    endtask

    // Apply the driven inputs for one clock and compare at the next falling edge.
    task automatic cycle(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL R11 watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; mode_sel = 2'b00; ref_sel = 2'b00;
        ref_fail = 3'b111; hitless = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 active", int'(active_ref), 0);
        check("R1 holdover", int'(holdover), 1);
        check("R1 strobe", int'(tie_strobe), 0);

        // R2 freerun until valid
        rst_n = 1'b1;
        cycle("R1"); cycle("R2");
        check("R2 freerun held", int'(holdover), 1);
        ref_fail = 3'b110; cycle("R2");
        check("R2 to normal", int'(holdover), 0);
        check("R2 no strobe", int'(tie_strobe), 0);

        // R4 manual hitless switch to tertiary
        ref_fail = 3'b000; ref_sel = 2'b10; cycle("R4");
        check("R4 strobe", int'(tie_strobe), 1);
        check("R4 new index", int'(active_ref), 2);
        cycle("R4");
        check("R4 strobe ends", int'(tie_strobe), 0);

        // R3 code 11 also selects tertiary
        ref_sel = 2'b11; cycle("R3");
        check("R3 active", int'(active_ref), 2);
        check("R3 report echo", int'(ref_rpt), 3);

        // R5 no alternative -> holdover, persists
        ref_fail = 3'b100; cycle("R5"); cycle("R5");
        check("R5 holdover", int'(holdover), 1);

        // R10 recovery paths
        hitless = 1'b0; ref_fail = 3'b000; cycle("R10");
        check("R10 direct", int'(holdover) + int'(tie_strobe), 0);
        ref_fail = 3'b100; cycle("R10");
        hitless = 1'b1; ref_fail = 3'b000; cycle("R10");
        check("R10 via strobe", int'(tie_strobe), 1);
        cycle("R10");

        // R8 enter auto on tertiary
        mode_sel = 2'b11; cycle("R8");
        check("R8 primary preferred", int'(active_ref), 0);
        cycle("R8");
        check("R8 report", int'(ref_rpt), 0);

        // R12 failover, R7 non-revertive
        ref_fail = 3'b001; cycle("R12");
        check("R12 strobe", int'(tie_strobe), 1);
        check("R12 index", int'(active_ref), 1);
        cycle("R12");
        ref_fail = 3'b000; cycle("R7"); cycle("R7"); cycle("R7");
        check("R7 stays secondary", int'(active_ref), 1);

        // R9 both fail -> holdover, index kept
        ref_fail = 3'b011; cycle("R9"); cycle("R9");
        check("R9 holdover", int'(holdover), 1);
        check("R9 index kept", int'(active_ref), 1);

        // R6 reset priority in automatic mode
        rst_n = 1'b0; cycle("R1"); cycle("R1");
        rst_n = 1'b1; ref_fail = 3'b000; hitless = 1'b0; cycle("R6");
        check("R6 primary", int'(active_ref), 0);
        check("R6 normal", int'(holdover), 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            for (int b = 0; b < 3; b++) begin
                if ($urandom_range(0, 9) == 0) ref_fail[b] = ~ref_fail[b];
            end
            if ($urandom_range(0, 31) == 0) mode_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) ref_sel  = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0)  hitless  = ~hitless;
            rst_n = ($urandom_range(0, 499) != 0);
            cycle((mode_sel == 2'b11) ? "R12" : "R3");
        end

        summary();
        $finish;
    end

endmodule